// File: doc/BRIEF.md
# Glitch-Free Clock/Buzzer Output Divider

This block drives one or more output pins, each with a square wave derived from one of two sources: the main clock itself, or a slower secondary clock. Each output channel owns an 8-bit control register. The register holds an output-enable bit, a bit that selects the source, and a 3-bit code k. The code sets the output to the source rate divided by 2^(k+1), with a 50% duty cycle. Software writes the register through a simple write port and can read any channel back through a read port.

All logic runs on the main clock. The secondary clock passes through a synchronizer and an edge detector, which turn it into a tick that advances the divider. A change of the enable bit passes through a two-stage synchronizer that is stepped by the selected source tick. The divider starts and stops only while its output is low, so every high pulse and every low phase on the pin has full width. The divider setting is captured when a channel starts running. Writes to the select fields are refused while the enable bit is set, so a running waveform never changes rate partway through a period.

Top module: `clkbuz_top`

## Requirements
- R1: After reset, every output pin is low and every channel reads back 0x00.
- R2: Each register reads back as follows: bit 7 is enable, bit 3 is the source select (0 = main clock, 1 = secondary clock), bits 2:0 are the divide code k, and bits 6:4 always read 0. A write always updates bit 7. While the stored enable is 0, a write also updates bits 3:0.
- R3: With the main source and code k, the output is a square wave that is high for 2^k main-clock cycles and low for 2^k main-clock cycles.
- R4: With the secondary source and code k, each output phase lasts 2^k rising edges of the secondary clock. The secondary clock runs at no more than a quarter of the main-clock rate.
- R5: A channel is idle when its divider has stopped and the enable bit has been 0 long enough to clear the synchronizer. When an idle channel on the main source is enabled, the first rising edge of its output follows the (3 + 2^k)-th main-clock rising edge after the write edge.
- R6: While the stored enable bit is 1, a write leaves bits 3:0 unchanged, both in the readback and in the output rate.
- R7: After the enable bit is cleared, the output stops while it is low. Every high pulse keeps its full width of 2^k source ticks, and the output stays low from then on.
- R8: While a channel is disabled, its output is held low and its divider returns to zero. A later enable therefore shows the same start latency as in R5.
- R9: Channels are independent. A write to one channel changes neither the readback nor the output of any other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mainClk | input | 1 | Main clock; clocks all logic and is the main output source |
| subClk | input | 1 | Secondary source clock, sampled by the main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | SEL_W | Channel addressed by the write |
| wrData | input | 8 | Register write data |
| rdSel | input | SEL_W | Channel addressed by the read |
| rdData | output | 8 | Readback of the addressed channel register |
| buzOut | output | NUM_OUT | One divided clock/buzzer output per channel |

## Verification
The divider is run from the main source with codes 0, 2 and 5. These cover the shortest output period, a middle one and a long one, and they expose an off-by-one in the counter bit chosen for the output. The secondary source is run with code 1. A phase of 16 main cycles confirms that the secondary tick, and not the main clock, drives the divider. The enable is cleared at six different offsets within a pulse; this separates a stop that waits for the low phase from one that truncates the pulse. A write that attempts a new divide code while the channel is enabled, and a check of a second channel that is not addressed, confirm that the refusal and the isolation between channels can be seen at the pins.

// File: rtl/clkbuz_pkg.sv
package clkbuz_pkg;
  localparam int unsigned DIV_BITS = 3;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned EN_POS   = 7;
  localparam int unsigned SRC_POS  = 3;

  typedef struct packed {
    logic                enable;
    logic                srcSel;
    logic [DIV_BITS-1:0] divSel;
    logic                subTick;
  } chCtl_t;
endpackage

// File: rtl/clkbuz_ctrl.sv
module clkbuz_ctrl
  import clkbuz_pkg::*;
#(
  parameter int unsigned NUM_OUT = 2,
  parameter int unsigned SEL_W   = 1
) (
  input  logic                       mainClk,
  input  logic                       subClk,
  input  logic                       rst_n,
  input  logic                       wrEn,
  input  logic [SEL_W-1:0]           wrSel,
  input  logic [REG_W-1:0]           wrData,
  input  logic [SEL_W-1:0]           rdSel,
  output logic [REG_W-1:0]           rdData,
  output chCtl_t [NUM_OUT-1:0]       chCtl
);
  logic [2:0]          subSync;
  logic                subTick;
  logic [NUM_OUT-1:0]  enQ;
  logic [NUM_OUT-1:0]  srcQ;
  logic [DIV_BITS-1:0] divQ [NUM_OUT];

  always_ff @(posedge mainClk or negedge rst_n) begin
    if (!rst_n) subSync <= '0;
    else        subSync <= {subSync[1:0], subClk};
  end
  assign subTick = subSync[1] & ~subSync[2];

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_reg
    logic hit;
    assign hit = wrEn && (wrSel == SEL_W'(i));
    always_ff @(posedge mainClk or negedge rst_n) begin
      if (!rst_n) begin
        enQ[i]  <= 1'b0;
        srcQ[i] <= 1'b0;
        divQ[i] <= '0;
      end else if (hit) begin
        enQ[i] <= wrData[EN_POS];
        if (!enQ[i]) begin
          srcQ[i] <= wrData[SRC_POS];
          divQ[i] <= wrData[DIV_BITS-1:0];
        end
      end
    end
    assign chCtl[i] = '{enable: enQ[i], srcSel: srcQ[i], divSel: divQ[i], subTick: subTick};
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_OUT; i++) begin
      if (rdSel == SEL_W'(i)) begin
        rdData[EN_POS]         = enQ[i];
        rdData[SRC_POS]        = srcQ[i];
        rdData[DIV_BITS-1:0]   = divQ[i];
      end
    end
  end
endmodule

// File: rtl/clkbuz_div.sv
module clkbuz_div
  import clkbuz_pkg::*;
#(
  parameter int unsigned CNT_W = 1 << DIV_BITS
) (
  input  logic   mainClk,
  input  logic   rst_n,
  input  chCtl_t ctl,
  output logic   pinOut,
  output logic   running
);
  logic                enS1, enS2;
  logic                runQ, pinQ, actSrcQ;
  logic [DIV_BITS-1:0] actDivQ;
  logic [CNT_W-1:0]    cntQ, cntNext;
  logic                useSub, tick;

  assign useSub  = runQ ? actSrcQ : ctl.srcSel;
  assign tick    = useSub ? ctl.subTick : 1'b1;
  assign cntNext = cntQ + 1'b1;

  always_ff @(posedge mainClk or negedge rst_n) begin
    if (!rst_n) begin
      enS1    <= 1'b0;
      enS2    <= 1'b0;
      runQ    <= 1'b0;
      pinQ    <= 1'b0;
      actSrcQ <= 1'b0;
      actDivQ <= '0;
      cntQ    <= '0;
    end else if (tick) begin
      enS1 <= ctl.enable;
      enS2 <= enS1;
      if (!runQ) begin
        cntQ    <= '0;
        pinQ    <= 1'b0;
        actSrcQ <= ctl.srcSel;
        actDivQ <= ctl.divSel;
        runQ    <= enS2;
      end else if (!enS2 && !pinQ) begin
        runQ <= 1'b0;
        cntQ <= '0;
      end else begin
        cntQ <= cntNext;
        pinQ <= cntNext[actDivQ];
      end
    end
  end

  assign pinOut  = pinQ;
  assign running = runQ;
endmodule

// File: rtl/clkbuz_top.sv
module clkbuz_top
  import clkbuz_pkg::*;
#(
  parameter int unsigned NUM_OUT = 2,
  parameter int unsigned SEL_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic               mainClk,
  input  logic               subClk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [7:0]         wrData,
  input  logic [SEL_W-1:0]   rdSel,
  output logic [7:0]         rdData,
  output logic [NUM_OUT-1:0] buzOut
);
  chCtl_t [NUM_OUT-1:0] chCtl;
  logic   [NUM_OUT-1:0] chRun;

  clkbuz_ctrl #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_ctrl (
    .mainClk(mainClk), .subClk(subClk), .rst_n(rst_n),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .chCtl(chCtl)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_ch
    clkbuz_div u_div (
      .mainClk(mainClk), .rst_n(rst_n), .ctl(chCtl[i]),
      .pinOut(buzOut[i]), .running(chRun[i])
    );
  end
endmodule

// File: rtl/clkbuz_chk.sv
module clkbuz_chk #(
  parameter int unsigned NUM_OUT = 2,
  parameter int unsigned SEL_W   = 1
) (
  input logic               mainClk,
  input logic               rst_n,
  input logic               wrEn,
  input logic [SEL_W-1:0]   wrSel,
  input logic [7:0]         wrData,
  input logic [SEL_W-1:0]   rdSel,
  input logic [7:0]         rdData,
  input logic [NUM_OUT-1:0] buzOut,
  input logic [NUM_OUT-1:0] chRun
);
  p_en_update_r2: assert property (@(posedge mainClk) disable iff (!rst_n)
    (wrEn && wrSel == rdSel) |=> (rdSel != $past(rdSel) || rdData[7] == $past(wrData[7])));

  p_cfg_take_r2: assert property (@(posedge mainClk) disable iff (!rst_n)
    (wrEn && wrSel == rdSel && !rdData[7]) |=>
      (rdSel != $past(rdSel) || rdData[3:0] == $past(wrData[3:0])));

  p_cfg_hold_r6: assert property (@(posedge mainClk) disable iff (!rst_n)
    (wrEn && wrSel == rdSel && rdData[7]) |=>
      (rdSel != $past(rdSel) || rdData[3:0] == $past(rdData[3:0])));

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_chan
    p_stop_on_low_r7: assert property (@(posedge mainClk) disable iff (!rst_n)
      $fell(chRun[i]) |-> (!buzOut[i] && $past(!buzOut[i])));

    p_start_low_r5: assert property (@(posedge mainClk) disable iff (!rst_n)
      $rose(chRun[i]) |-> !buzOut[i]);

    p_idle_low_r8: assert property (@(posedge mainClk) disable iff (!rst_n)
      !chRun[i] |-> !buzOut[i]);
  end
endmodule

bind clkbuz_top clkbuz_chk #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) u_chk (
  .mainClk(mainClk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .rdSel(rdSel), .rdData(rdData), .buzOut(buzOut), .chRun(chRun)
);

// File: tb/clkbuz_tb_top.sv
`timescale 1ns/1ps
module clkbuz_tb_top;
  logic       mainClk = 1'b0;
  logic       subClk  = 1'b0;
  logic       rst_n   = 1'b0;
  logic       wrEn    = 1'b0;
  logic [0:0] wrSel   = '0;
  logic [7:0] wrData  = '0;
  logic [0:0] rdSel   = '0;
  logic [7:0] rdData;
  logic [1:0] buzOut;
  int total = 0;
  int bad   = 0;

  clkbuz_top #(.NUM_OUT(2)) dut_i (
    .mainClk(mainClk), .subClk(subClk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .buzOut(buzOut)
  );

  always #2.5 mainClk = ~mainClk;
  initial begin #1; forever #20 subClk = ~subClk; end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int data);
    @(negedge mainClk);
    wrEn = 1'b1; wrSel = ch[0:0]; wrData = data[7:0];
    @(negedge mainClk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int ch, output int val);
    rdSel = ch[0:0];
    #0.5;
    val = int'(rdData);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge mainClk);
  endtask

  // Measure one high phase and the following low phase on a channel
  task automatic measure(input int ch, input string req, input int expHi, input int expLo);
    int hi = 0, lo = 0, w = 0;
    while (!buzOut[ch] && w < 2000) begin @(negedge mainClk); w++; end
    while (buzOut[ch] && hi < 2000) begin hi++; @(negedge mainClk); end
    while (!buzOut[ch] && lo < 2000) begin lo++; @(negedge mainClk); end
    chk(hi == expHi, req, "high width", hi, expHi);
    chk(lo == expLo, req, "low width", lo, expLo);
  endtask

  task automatic t_reset();
    int v;
    rd(0, v); chk(v == 0, "R1", "ch0 readback", v, 0);
    rd(1, v); chk(v == 0, "R1", "ch1 readback", v, 0);
    chk(buzOut == 2'b00, "R1", "outputs", int'(buzOut), 0);
  endtask

  task automatic t_readback();
    int v;
    wr(1, 8'h0D); rd(1, v); chk(v == 8'h0D, "R2", "cfg while off", v, 8'h0D);
    wr(1, 8'h70); rd(1, v); chk(v == 8'h00, "R2", "bits 6:4 read zero", v, 0);
    wr(1, 8'hF7); rd(1, v); chk(v == 8'h87, "R2", "enable with cfg", v, 8'h87);
    wr(1, 8'h00); rd(1, v); chk(v == 8'h07, "R6", "cfg kept on disabling write", v, 8'h07);
    idle(600);
  endtask

  // R5/R8: first rising edge after the (3+2^k)-th edge following the write edge
  task automatic t_latency(input int k, input string req);
    int first = -1;
    @(negedge mainClk);
    wrEn = 1'b1; wrSel = 1'b0; wrData = 8'h80 | k[7:0];
    @(negedge mainClk);
    wrEn = 1'b0;
    for (int j = 1; j <= 40; j++) begin
      @(negedge mainClk);
      if (buzOut[0] && first < 0) first = j;
    end
    chk(first == 3 + (1 << k), req, "start latency", first, 3 + (1 << k));
    wr(0, k);
    idle((2 << k) + 40);
  endtask

  task automatic t_freq(input int k);
    wr(0, 8'h80 | k);
    measure(0, "R3", 1 << k, 1 << k);
    wr(0, k);
    idle((2 << k) + 40);
  endtask

  task automatic t_ignore();
    int v, v0, stray = 0;
    rd(0, v0);
    wr(1, 8'h81);
    wr(1, 8'h85); rd(1, v); chk(v == 8'h81, "R6", "cfg write refused", v, 8'h81);
    measure(1, "R6", 2, 2);
    for (int j = 0; j < 40; j++) begin
      @(negedge mainClk);
      if (buzOut[0]) stray++;
    end
    chk(stray == 0, "R9", "other output quiet", stray, 0);
    rd(0, v); chk(v == v0, "R9", "other readback", v, v0);
    wr(1, 8'h05); rd(1, v); chk(v == 8'h01, "R6", "disable keeps cfg", v, 8'h01);
    idle(60);
  endtask

  task automatic t_sub();
    int v;
    wr(0, 8'h89); rd(0, v); chk(v == 8'h89, "R2", "secondary cfg", v, 8'h89);
    measure(0, "R4", 16, 16);
    wr(0, 8'h09);
    idle(300);
  endtask

  task automatic t_stop(input int off);
    int hi = 1, runt = 0, tailHigh = 0, w = 0;
    wr(0, 8'h82);
    while (!buzOut[0] && w < 200) begin @(negedge mainClk); w++; end
    for (int c = 0; c < 80; c++) begin
      @(negedge mainClk);
      wrEn = (c == off);
      wrSel = 1'b0; wrData = 8'h02;
      if (buzOut[0]) hi++;
      else if (hi > 0) begin
        if (hi != 4) runt++;
        hi = 0;
      end
      if (c >= 60 && buzOut[0]) tailHigh++;
    end
    wrEn = 1'b0;
    chk(runt == 0, "R7", $sformatf("pulse width off=%0d", off), runt, 0);
    chk(tailHigh == 0, "R7", $sformatf("stays low off=%0d", off), tailHigh, 0);
    idle(20);
  endtask

  initial begin
    repeat (4) @(negedge mainClk);
    rst_n = 1'b1;
    repeat (2) @(negedge mainClk);
    t_reset();
    t_readback();
    t_latency(0, "R5");
    t_latency(2, "R5");
    t_freq(0);
    t_freq(2);
    t_freq(5);
    t_ignore();
    t_sub();
    for (int off = 0; off < 6; off++) t_stop(off);
    t_latency(2, "R8");
    begin
      int hiCnt = 0;
      for (int j = 0; j < 50; j++) begin
        @(negedge mainClk);
        if (buzOut != 2'b00) hiCnt++;
      end
      chk(hiCnt == 0, "R8", "held low while off", hiCnt, 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge mainClk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule